// File: doc/BRIEF.md
# Vector Element Category and Enable Unit

This block sorts every element index of a vector destination into one of four categories. An element below the resume point is *prestart*. An element between the resume point and the vector length is *body*, and a body element is either *active* or *inactive* depending on its mask bit. An element at or past the vector length is *tail*. An element at or past the group capacity lies outside the register group. From this category the block derives three per-element enables: a write enable, a fault-report enable and an agnostic-fill flag. It also produces a valid signal for instructions whose result goes to a scalar register.

The datapath uses the write enable to gate its element writes. The fill flag tells the datapath to write all ones in place of a computed value, under the agnostic policy. The memory side uses the fault-report enable, so a lane that is masked off or not yet started never raises a fault.

When the body is empty, because the resume point is at or beyond the vector length, nothing is written at all, and that includes agnostic fills. A scalar result is still delivered in this case.

All decisions are made combinationally from the inputs and are captured in one output register stage. Results therefore appear one clock after the inputs.

Top module: `vec_elem_gate`

## Requirements
- R1: An element whose index is below `vstart_i` (and whose body is non-empty) has write, fault and fill all deasserted.
- R2: When masking is enabled, a body element (index in `[vstart_i, vl_i)`) whose bit in `mask_i` is 1 is active. An active element has write = 1, fault = 1 and fill = 0.
- R3: A body element whose mask bit is 0 while masking is enabled is inactive and has fault = 0. Its write and fill both equal the effective inactive policy: 1 = agnostic, 0 = undisturbed.
- R4: With `mask_en_i` = 0, every body element is active regardless of `mask_i`.
- R5: A tail element (index ≥ `vl_i` and below `vlmax_i`) has fault = 0. Its write and fill both equal the effective tail policy: 1 = agnostic, 0 = undisturbed.
- R6: `force_agn_i` = 1 makes both the tail policy and the inactive policy agnostic, whatever `tail_agn_i` and `inact_agn_i` hold.
- R7: When `vstart_i` ≥ `vl_i`, all three enable vectors are entirely zero, including agnostic fills.
- R8: `scalar_vld_o` equals `scalar_op_i` from the previous cycle, independent of `vstart_i` and `vl_i`, including `vl_i` = 0.
- R9: Elements with index ≥ `vlmax_i` have every enable deasserted, even when `vl_i` exceeds `vlmax_i`.
- R10: Outputs reflect the inputs sampled at the previous rising clock edge. A synchronous low on `rst_n` clears all outputs to zero at the next edge.
- R11: With `vstart_i` = 2, `vl_i` = 6, `vlmax_i` = 8, `mask_i` = 8'hAA, masking enabled, tail agnostic and inactive undisturbed, the outputs are: write = 8'hE8, fault = 8'h28, fill = 8'hC0. This places element 1 in prestart, element 3 in the active body, element 4 in the inactive body and element 7 in the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vstart_i | input | IDX_W | First element index to process (resume point) |
| vl_i | input | IDX_W | Vector length: first tail index |
| vlmax_i | input | IDX_W | Group capacity in elements |
| mask_i | input | NUM_ELEM | Per-element mask bits |
| mask_en_i | input | 1 | 1 = instruction is masked |
| tail_agn_i | input | 1 | Tail policy: 1 = agnostic |
| inact_agn_i | input | 1 | Inactive-element policy: 1 = agnostic |
| force_agn_i | input | 1 | Forces both policies to agnostic |
| scalar_op_i | input | 1 | Instruction produces a scalar-register result |
| wr_en_o | output | NUM_ELEM | Per-element write enable |
| fault_en_o | output | NUM_ELEM | Per-element fault-report enable |
| fill_o | output | NUM_ELEM | Per-element agnostic fill (write all ones) |
| scalar_vld_o | output | 1 | Scalar result valid |

## Verification
The bench instantiates the block with `NUM_ELEM` = 8, which gives `IDX_W` = 4. With this width, all 729 combinations of `vstart_i`, `vl_i` and `vlmax_i` from 0 to 8 can be swept exhaustively, with random masks and policy bits on each step.

That sweep covers the cases that matter: empty bodies, a zero length, a length larger than the capacity, and a resume point past the capacity. It is followed by a random phase that also draws 4-bit values above 8. A final directed step checks the worked example of R11 bit for bit.

// File: rtl/vec_elem_pkg.sv
// Package: shared types for the vector element enable unit.
// Assumes: nothing beyond IEEE 1800-2017.
package vec_elem_pkg;

    // Category an element index falls into for one instruction.
    typedef enum logic [2:0] {
        CLS_OUTSIDE  = 3'd0,   // index at or beyond group capacity
        CLS_PRESTART = 3'd1,   // index below resume point
        CLS_ACTIVE   = 3'd2,   // body, mask on or masking off
        CLS_INACTIVE = 3'd3,   // body, mask off
        CLS_TAIL     = 3'd4    // index at or beyond vector length
    } elem_class_e;

endpackage

// File: rtl/vec_elem_classify.sv
// Module: vec_elem_classify
// Sorts each element index into its category by comparing the index with
// the resume point, the vector length and the group capacity.
// Assumes: NUM_ELEM < 2**IDX_W, so every index fits in IDX_W bits.
// Purely combinational.
module vec_elem_classify
    import vec_elem_pkg::*;
#(
    parameter int unsigned NUM_ELEM = 16,
    parameter int unsigned IDX_W    = $clog2(NUM_ELEM + 1)
) (
    input  logic [IDX_W-1:0]                vstart_i,
    input  logic [IDX_W-1:0]                vl_i,
    input  logic [IDX_W-1:0]                vlmax_i,
    input  logic [NUM_ELEM-1:0]             mask_i,
    input  logic                            mask_en_i,
    output elem_class_e [NUM_ELEM-1:0]      cls_o,
    output logic                            body_empty_o
);

    // Empty body: resume point at or past the vector length.
    always_comb begin
        body_empty_o = (vstart_i >= vl_i);
    end

    for (genvar e = 0; e < NUM_ELEM; e++) begin : g_elem
        localparam logic [IDX_W-1:0] EIDX = IDX_W'(e);

        // Category of element e, with capacity checked first.
        always_comb begin
            if (EIDX >= vlmax_i) begin
                cls_o[e] = CLS_OUTSIDE;
            end else if (EIDX < vstart_i) begin
                cls_o[e] = CLS_PRESTART;
            end else if (EIDX >= vl_i) begin
                cls_o[e] = CLS_TAIL;
            end else if (!mask_en_i || mask_i[e]) begin
                cls_o[e] = CLS_ACTIVE;
            end else begin
                cls_o[e] = CLS_INACTIVE;
            end
        end
    end

endmodule

// File: rtl/vec_elem_policy.sv
// Module: vec_elem_policy
// Turns each element category into write, fault and fill enables, applying
// the tail and inactive policies and the global empty-body squash.
// Assumes: categories come from vec_elem_classify. Purely combinational.
module vec_elem_policy
    import vec_elem_pkg::*;
#(
    parameter int unsigned NUM_ELEM = 16
) (
    input  elem_class_e [NUM_ELEM-1:0]  cls_i,
    input  logic                        body_empty_i,
    input  logic                        tail_agn_i,
    input  logic                        inact_agn_i,
    input  logic                        force_agn_i,
    output logic [NUM_ELEM-1:0]         wr_en_o,
    output logic [NUM_ELEM-1:0]         fault_en_o,
    output logic [NUM_ELEM-1:0]         fill_o
);

    logic tail_fill;
    logic inact_fill;

    // Effective policies after the force-agnostic override.
    always_comb begin
        tail_fill  = tail_agn_i  | force_agn_i;
        inact_fill = inact_agn_i | force_agn_i;
    end

    for (genvar e = 0; e < NUM_ELEM; e++) begin : g_elem
        // Enables for element e, all squashed when the body is empty.
        always_comb begin
            wr_en_o[e]    = 1'b0;
            fault_en_o[e] = 1'b0;
            fill_o[e]     = 1'b0;
            if (!body_empty_i) begin
                unique case (cls_i[e])
                    CLS_ACTIVE: begin
                        wr_en_o[e]    = 1'b1;
                        fault_en_o[e] = 1'b1;
                    end
                    CLS_INACTIVE: begin
                        wr_en_o[e] = inact_fill;
                        fill_o[e]  = inact_fill;
                    end
                    CLS_TAIL: begin
                        wr_en_o[e] = tail_fill;
                        fill_o[e]  = tail_fill;
                    end
                    default: begin
                        wr_en_o[e] = 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/vec_elem_gate.sv
// Module: vec_elem_gate (top)
// Per-element write, fault and agnostic-fill enables for a vector
// destination, plus scalar-result valid, registered once at the output.
// Assumes: synchronous active-low reset; NUM_ELEM < 2**IDX_W.
module vec_elem_gate
    import vec_elem_pkg::*;
#(
    parameter int unsigned NUM_ELEM = 16,
    parameter int unsigned IDX_W    = $clog2(NUM_ELEM + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_W-1:0]     vstart_i,
    input  logic [IDX_W-1:0]     vl_i,
    input  logic [IDX_W-1:0]     vlmax_i,
    input  logic [NUM_ELEM-1:0]  mask_i,
    input  logic                 mask_en_i,
    input  logic                 tail_agn_i,
    input  logic                 inact_agn_i,
    input  logic                 force_agn_i,
    input  logic                 scalar_op_i,
    output logic [NUM_ELEM-1:0]  wr_en_o,
    output logic [NUM_ELEM-1:0]  fault_en_o,
    output logic [NUM_ELEM-1:0]  fill_o,
    output logic                 scalar_vld_o
);

    elem_class_e [NUM_ELEM-1:0] cls;
    logic                       body_empty;
    logic [NUM_ELEM-1:0]        wr_nxt;
    logic [NUM_ELEM-1:0]        fault_nxt;
    logic [NUM_ELEM-1:0]        fill_nxt;

    vec_elem_classify #(
        .NUM_ELEM (NUM_ELEM),
        .IDX_W    (IDX_W)
    ) u_classify (
        .vstart_i     (vstart_i),
        .vl_i         (vl_i),
        .vlmax_i      (vlmax_i),
        .mask_i       (mask_i),
        .mask_en_i    (mask_en_i),
        .cls_o        (cls),
        .body_empty_o (body_empty)
    );

    vec_elem_policy #(
        .NUM_ELEM (NUM_ELEM)
    ) u_policy (
        .cls_i        (cls),
        .body_empty_i (body_empty),
        .tail_agn_i   (tail_agn_i),
        .inact_agn_i  (inact_agn_i),
        .force_agn_i  (force_agn_i),
        .wr_en_o      (wr_nxt),
        .fault_en_o   (fault_nxt),
        .fill_o       (fill_nxt)
    );

    // Output stage: capture enables and scalar valid, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en_o      <= '0;
            fault_en_o   <= '0;
            fill_o       <= '0;
            scalar_vld_o <= 1'b0;
        end else begin
            wr_en_o      <= wr_nxt;
            fault_en_o   <= fault_nxt;
            fill_o       <= fill_nxt;
            scalar_vld_o <= scalar_op_i;
        end
    end

endmodule

// File: rtl/vec_elem_gate_chk.sv
// Module: vec_elem_gate_chk
// Assertion checker bound to vec_elem_gate. It relates the registered
// outputs to the inputs one cycle earlier.
// Assumes: checks start once one non-reset edge has loaded the outputs.
module vec_elem_gate_chk #(
    parameter int unsigned NUM_ELEM = 16,
    parameter int unsigned IDX_W    = $clog2(NUM_ELEM + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [IDX_W-1:0]     vstart_i,
    input logic [IDX_W-1:0]     vl_i,
    input logic [IDX_W-1:0]     vlmax_i,
    input logic                 scalar_op_i,
    input logic [NUM_ELEM-1:0]  wr_en_o,
    input logic [NUM_ELEM-1:0]  fault_en_o,
    input logic [NUM_ELEM-1:0]  fill_o,
    input logic                 scalar_vld_o
);

    logic primed;

    // Marks that the outputs hold values computed from live inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    function automatic logic [NUM_ELEM-1:0] below(input logic [IDX_W-1:0] n);
        logic [NUM_ELEM-1:0] m;
        for (int j = 0; j < NUM_ELEM; j++) begin
            m[j] = (IDX_W'(j) < n);
        end
        return m;
    endfunction

    assert_prestart_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        ((wr_en_o | fault_en_o | fill_o) & below($past(vstart_i))) == '0);

    assert_fault_implies_write_R2: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        ((fault_en_o & ~wr_en_o) | (fault_en_o & fill_o)) == '0);

    assert_fill_implies_write_R5: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        (fill_o & ~wr_en_o) == '0);

    assert_empty_body_silent_R7: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        ($past(vstart_i) >= $past(vl_i)) |-> ((wr_en_o | fault_en_o | fill_o) == '0));

    assert_scalar_delivered_R8: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        scalar_vld_o == $past(scalar_op_i));

    assert_outside_group_R9: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        ((wr_en_o | fault_en_o | fill_o) & ~below($past(vlmax_i))) == '0);

    assert_faults_in_body_R3: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        (fault_en_o & ~below($past(vl_i))) == '0);

endmodule

bind vec_elem_gate vec_elem_gate_chk #(
    .NUM_ELEM (NUM_ELEM),
    .IDX_W    (IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .vstart_i     (vstart_i),
    .vl_i         (vl_i),
    .vlmax_i      (vlmax_i),
    .scalar_op_i  (scalar_op_i),
    .wr_en_o      (wr_en_o),
    .fault_en_o   (fault_en_o),
    .fill_o       (fill_o),
    .scalar_vld_o (scalar_vld_o)
);

// File: tb/test_vec_elem_gate.sv
`timescale 1ns/1ps
// Bench for vec_elem_gate: behavioural reference model compared every clock.
module test_vec_elem_gate;

    localparam int N  = 8;
    localparam int IW = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [IW-1:0] vstart = '0, vl = '0, vlmax = '0;
    logic [N-1:0]  mask = '0;
    logic          mask_en = 1'b0, tail_agn = 1'b0, inact_agn = 1'b0;
    logic          force_agn = 1'b0, scalar_op = 1'b0;
    logic [N-1:0]  wr_en, fault_en, fill;
    logic          scalar_vld;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    vec_elem_gate #(.NUM_ELEM(N)) i_vec_elem_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .vstart_i     (vstart),
        .vl_i         (vl),
        .vlmax_i      (vlmax),
        .mask_i       (mask),
        .mask_en_i    (mask_en),
        .tail_agn_i   (tail_agn),
        .inact_agn_i  (inact_agn),
        .force_agn_i  (force_agn),
        .scalar_op_i  (scalar_op),
        .wr_en_o      (wr_en),
        .fault_en_o   (fault_en),
        .fill_o       (fill),
        .scalar_vld_o (scalar_vld)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp,
                         input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive one input set, wait one clock, compare against the reference model.
    task automatic apply(input int vs, input int l, input int vm, input logic [N-1:0] m,
                         input logic me, input logic ta, input logic ia, input logic fa,
                         input logic so);
        logic [N-1:0] ew, ef, eg;
        string tag;
        vstart = IW'(vs); vl = IW'(l); vlmax = IW'(vm); mask = m;
        mask_en = me; tail_agn = ta; inact_agn = ia; force_agn = fa; scalar_op = so;
        ew = '0; ef = '0; eg = '0;
        tag = "R2";
        for (int e = 0; e < N; e++) begin
            if (e >= vm) begin
                if (e < l) tag = "R9";
            end else if (vs >= l) begin
                tag = "R7";
            end else if (e < vs) begin
                tag = "R1";
            end else if (e < l) begin
                if (!me || m[e]) begin
                    ew[e] = 1'b1; ef[e] = 1'b1;
                    if (!me) tag = "R4";
                end else begin
                    ew[e] = ia || fa; eg[e] = ia || fa;
                    tag = fa ? "R6" : "R3";
                end
            end else begin
                ew[e] = ta || fa; eg[e] = ta || fa;
                tag = fa ? "R6" : "R5";
            end
        end
        @(negedge clk);
        check(tag, wr_en, ew, "write");
        check(tag, fault_en, ef, "fault");
        check(tag, fill, eg, "fill");
        check("R8", {{(N-1){1'b0}}, scalar_vld}, {{(N-1){1'b0}}, so}, "scalar");
    endtask

    initial begin
        // R10: outputs clear under reset even with busy inputs.
        vstart = 0; vl = 8; vlmax = 8; mask = '1; mask_en = 1'b0; tail_agn = 1'b1;
        scalar_op = 1'b1;
        repeat (3) @(negedge clk);
        check("R10", wr_en | fault_en | fill, '0, "reset enables");
        check("R10", {{(N-1){1'b0}}, scalar_vld}, '0, "reset scalar");
        rst_n = 1'b1;

        // R11: worked example.
        apply(2, 6, 8, 8'hAA, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R11", wr_en, 8'hE8, "example write");
        check("R11", fault_en, 8'h28, "example fault");
        check("R11", fill, 8'hC0, "example fill");

        // R7/R8: empty body and zero length still deliver scalar result.
        apply(0, 0, 8, 8'hFF, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        apply(5, 3, 8, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        // R6: force overrides undisturbed policies.
        apply(1, 4, 8, 8'h05, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        // R9: length beyond capacity.
        apply(0, 8, 4, 8'hFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);

        // Exhaustive sweep of the three indices with random mask and policy.
        for (int a = 0; a <= N; a++)
            for (int b = 0; b <= N; b++)
                for (int c = 0; c <= N; c++) begin
                    logic [7:0] r;
                    r = 8'($urandom);
                    apply(c, b, a, N'($urandom), r[0], r[1], r[2], r[3] & r[4], r[5]);
                end

        // Random phase including out-of-range 4-bit values.
        for (int k = 0; k < 2000; k++) begin
            logic [7:0] r;
            r = 8'($urandom);
            apply(int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
                  int'($urandom_range(0, 15)), N'($urandom),
                  r[0], r[1], r[2], r[3], r[4]);
        end

        // R10: mid-run reset clears outputs.
        rst_n = 1'b0;
        vstart = 0; vl = 8; vlmax = 8; mask_en = 1'b0; scalar_op = 1'b1;
        @(negedge clk);
        check("R10", wr_en | fault_en | fill, '0, "mid-run reset");
        rst_n = 1'b1;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R10 watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule